// File: doc/BRIEF.md
# Multicycle CPU Control Sequencer

This block is the controller for a small 8-bit, multicycle processor datapath that runs a subset of a common RISC instruction set. A state register steps the datapath through fetch, decode, execute, memory access and write-back. Every control output is a function of the current state alone, which makes this a Moore machine. The only data input is the 6-bit opcode field of the instruction register. The controller uses that field to pick the path through the states.

An instruction is 32 bits wide and the memory port is 8 bits wide. Fetch therefore takes four cycles. Each cycle loads one byte into the instruction register and increments the program counter by one through the ALU. After that comes one decode cycle. It computes a branch target and dispatches on the opcode to a short per-instruction sequence. The machine then returns to the first fetch state.

The state uses a fixed 4-bit binary encoding. The datapath, the ALU, the register file, the memory and the ALU decoder that reads the function field all sit outside this block. Every pin is a plain control level with no handshake. The datapath is expected to act on each control level in the same cycle that it is presented.

Top module: `cpu_seq_ctrl`

## Requirements
- R1: While `rst` is high, every output is 0. The next edge leaves the machine in fetch byte 0. Once `rst` is low, that state's outputs appear.
- R2: Fetch occupies four consecutive cycles, numbered k = 0 to 3.
  - In each fetch cycle, `mem_rd`=1, `ir_wr` has only bit k set, `pc_wr`=1 and `pc_sel`=00 (ALU result).
  - The ALU controls are `alu_a_sel`=0 (PC), `alu_b_sel`=01 (constant one) and `alu_class`=00 (add).
- R3: Decode is one cycle, entered after fetch byte 3.
  - Its outputs are `alu_a_sel`=0, `alu_b_sel`=11 (shifted offset) and `alu_class`=00. Every other output is 0.
  - The opcode held during decode picks the next path: 100000 is load byte, 101000 is store byte, 000000 is register-register, 001000 is add-immediate, 000100 is branch-equal and 000010 is jump.
- R4: Load byte and store byte first pass through an address cycle with `alu_a_sel`=1, `alu_b_sel`=10 (immediate) and `alu_class`=00. If the opcode in that cycle is 101000, the store path follows. For any other opcode, the read path follows.
- R5: The load path reads memory with `mem_rd`=1 and `addr_sel`=1. It then writes the register with `reg_wr`=1, `wb_sel`=1 and `dst_sel`=0. Load byte takes 8 cycles from fetch byte 0 back to fetch byte 0.
- R6: The store path is one cycle with `mem_wr`=1 and `addr_sel`=1. Store byte takes 7 cycles.
- R7: Register-register takes 7 cycles.
  - Execute cycle: `alu_a_sel`=1, `alu_b_sel`=00 (register), `alu_class`=10 (function field).
  - Write cycle: `reg_wr`=1, `dst_sel`=1, `wb_sel`=0.
- R8: Add-immediate takes 7 cycles.
  - Execute cycle: `alu_a_sel`=1, `alu_b_sel`=10, `alu_class`=00.
  - Write cycle: `reg_wr`=1, `dst_sel`=0, `wb_sel`=0.
- R9: Branch-equal is one cycle with `alu_a_sel`=1, `alu_b_sel`=00, `alu_class`=01 (subtract), `br_en`=1, `pc_sel`=01 (stored target) and `pc_wr`=0. It takes 6 cycles.
- R10: Jump is one cycle with `pc_wr`=1 and `pc_sel`=10 (jump address). It takes 6 cycles.
- R11: Any other opcode in decode returns the machine to fetch byte 0. That instruction takes 5 cycles and asserts no enable after fetch.
- R12: Any output that a requirement does not name for a state is 0 in that state. `mem_rd` and `mem_wr` are never both 1. `ir_wr` never has more than one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the instruction register |
| ir_wr | output | 4 | Per-byte instruction register write enables |
| pc_wr | output | 1 | Unconditional program counter write |
| br_en | output | 1 | Branch enable, PC written when the ALU reports zero |
| pc_sel | output | 2 | PC source: 00 ALU, 01 stored target, 10 jump address |
| addr_sel | output | 1 | Memory address: 0 PC, 1 ALU result register |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| alu_a_sel | output | 1 | ALU A: 0 PC, 1 register operand |
| alu_b_sel | output | 2 | ALU B: 00 register, 01 one, 10 immediate, 11 shifted offset |
| alu_class | output | 2 | ALU operation class: 00 add, 01 subtract, 10 function field |
| dst_sel | output | 1 | Destination register: 0 rt field, 1 rd field |
| reg_wr | output | 1 | Register file write |
| wb_sel | output | 1 | Write-back data: 0 ALU result, 1 memory data |

## Verification
The outputs come from the state register alone. A state's control levels are therefore due in the cycle that follows the rising edge that enters it. The opcode presented during decode or the address cycle shows its effect one edge later. The bench follows its own model of the state sequence. It drives inputs and compares every output at the falling edge, so every sample falls half a period after the register settles. Reset gating is combinational, so the zero outputs under `rst` are checked in the same cycle, with no edge in between. Instruction length is checked by counting edges from fetch byte 0 until the model returns to it.

// File: rtl/cpu_seq_pkg.sv
package cpu_seq_pkg;

  localparam int OP_W     = 6;
  localparam int STATE_W  = 4;
  localparam int IR_BYTES = 4;

  typedef enum logic [STATE_W-1:0] {
    ST_FETCH0    = 4'd0,
    ST_FETCH1    = 4'd1,
    ST_FETCH2    = 4'd2,
    ST_FETCH3    = 4'd3,
    ST_DECODE    = 4'd4,
    ST_MEM_ADDR  = 4'd5,
    ST_MEM_READ  = 4'd6,
    ST_MEM_WB    = 4'd7,
    ST_MEM_WRITE = 4'd8,
    ST_R_EXEC    = 4'd9,
    ST_R_WB      = 4'd10,
    ST_BRANCH    = 4'd11,
    ST_JUMP      = 4'd12,
    ST_AI_EXEC   = 4'd13,
    ST_AI_WB     = 4'd14
  } state_e;

  localparam logic [OP_W-1:0] OP_RTYPE = 6'b000000;
  localparam logic [OP_W-1:0] OP_JUMP  = 6'b000010;
  localparam logic [OP_W-1:0] OP_BEQ   = 6'b000100;
  localparam logic [OP_W-1:0] OP_ADDI  = 6'b001000;
  localparam logic [OP_W-1:0] OP_LB    = 6'b100000;
  localparam logic [OP_W-1:0] OP_SB    = 6'b101000;

  localparam logic [1:0] SRCB_REG = 2'b00;
  localparam logic [1:0] SRCB_ONE = 2'b01;
  localparam logic [1:0] SRCB_IMM = 2'b10;
  localparam logic [1:0] SRCB_OFS = 2'b11;

  localparam logic [1:0] ALU_ADD   = 2'b00;
  localparam logic [1:0] ALU_SUB   = 2'b01;
  localparam logic [1:0] ALU_FUNCT = 2'b10;

  localparam logic [1:0] PCS_ALU    = 2'b00;
  localparam logic [1:0] PCS_TARGET = 2'b01;
  localparam logic [1:0] PCS_JUMP   = 2'b10;

  typedef struct packed {
    logic [IR_BYTES-1:0] ir_wr;
    logic                pc_wr;
    logic                br_en;
    logic [1:0]          pc_sel;
    logic                addr_sel;
    logic                mem_rd;
    logic                mem_wr;
    logic                alu_a_sel;
    logic [1:0]          alu_b_sel;
    logic [1:0]          alu_class;
    logic                dst_sel;
    logic                reg_wr;
    logic                wb_sel;
  } ctrl_t;

endpackage

// File: rtl/cpu_seq_next.sv
module cpu_seq_next
  import cpu_seq_pkg::*;
(
  input  state_e          cur,
  input  logic [OP_W-1:0] opcode,
  output state_e          nxt
);

  always_comb begin
    nxt = ST_FETCH0;
    case (cur)
      ST_FETCH0:   nxt = ST_FETCH1;
      ST_FETCH1:   nxt = ST_FETCH2;
      ST_FETCH2:   nxt = ST_FETCH3;
      ST_FETCH3:   nxt = ST_DECODE;
      ST_DECODE: begin
        case (opcode)
          OP_LB, OP_SB: nxt = ST_MEM_ADDR;
          OP_RTYPE:     nxt = ST_R_EXEC;
          OP_BEQ:       nxt = ST_BRANCH;
          OP_JUMP:      nxt = ST_JUMP;
          OP_ADDI:      nxt = ST_AI_EXEC;
          default:      nxt = ST_FETCH0;
        endcase
      end
      ST_MEM_ADDR: nxt = (opcode == OP_SB) ? ST_MEM_WRITE : ST_MEM_READ;
      ST_MEM_READ: nxt = ST_MEM_WB;
      ST_R_EXEC:   nxt = ST_R_WB;
      ST_AI_EXEC:  nxt = ST_AI_WB;
      default:     nxt = ST_FETCH0;
    endcase
  end

endmodule

// File: rtl/cpu_seq_decode.sv
module cpu_seq_decode
  import cpu_seq_pkg::*;
(
  input  logic   rst,
  input  state_e st,
  output ctrl_t  ctrl
);

  logic [IR_BYTES-1:0] byte_hit;

  // One instruction register byte enable per fetch state.
  for (genvar i = 0; i < IR_BYTES; i++) begin : g_byte
    assign byte_hit[i] = (st == state_e'(i));
  end

  ctrl_t raw;

  always_comb begin
    raw = '0;
    case (st)
      ST_FETCH0, ST_FETCH1, ST_FETCH2, ST_FETCH3: begin
        raw.mem_rd    = 1'b1;
        raw.pc_wr     = 1'b1;
        raw.pc_sel    = PCS_ALU;
        raw.alu_b_sel = SRCB_ONE;
        raw.alu_class = ALU_ADD;
      end
      ST_DECODE: begin
        raw.alu_b_sel = SRCB_OFS;
        raw.alu_class = ALU_ADD;
      end
      ST_MEM_ADDR, ST_AI_EXEC: begin
        raw.alu_a_sel = 1'b1;
        raw.alu_b_sel = SRCB_IMM;
        raw.alu_class = ALU_ADD;
      end
      ST_MEM_READ: begin
        raw.mem_rd   = 1'b1;
        raw.addr_sel = 1'b1;
      end
      ST_MEM_WB: begin
        raw.reg_wr = 1'b1;
        raw.wb_sel = 1'b1;
      end
      ST_MEM_WRITE: begin
        raw.mem_wr   = 1'b1;
        raw.addr_sel = 1'b1;
      end
      ST_R_EXEC: begin
        raw.alu_a_sel = 1'b1;
        raw.alu_b_sel = SRCB_REG;
        raw.alu_class = ALU_FUNCT;
      end
      ST_R_WB: begin
        raw.reg_wr  = 1'b1;
        raw.dst_sel = 1'b1;
      end
      ST_BRANCH: begin
        raw.alu_a_sel = 1'b1;
        raw.alu_b_sel = SRCB_REG;
        raw.alu_class = ALU_SUB;
        raw.br_en     = 1'b1;
        raw.pc_sel    = PCS_TARGET;
      end
      ST_JUMP: begin
        raw.pc_wr  = 1'b1;
        raw.pc_sel = PCS_JUMP;
      end
      ST_AI_WB: begin
        raw.reg_wr = 1'b1;
      end
      default: raw = '0;
    endcase
    raw.ir_wr = byte_hit;
  end

  assign ctrl = rst ? '0 : raw;

endmodule

// File: rtl/cpu_seq_ctrl.sv
module cpu_seq_ctrl
  import cpu_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [5:0] opcode,
  output logic [3:0] ir_wr,
  output logic       pc_wr,
  output logic       br_en,
  output logic [1:0] pc_sel,
  output logic       addr_sel,
  output logic       mem_rd,
  output logic       mem_wr,
  output logic       alu_a_sel,
  output logic [1:0] alu_b_sel,
  output logic [1:0] alu_class,
  output logic       dst_sel,
  output logic       reg_wr,
  output logic       wb_sel
);

  state_e state;
  state_e state_nxt;
  ctrl_t  ctrl;

  cpu_seq_next u_next (
    .cur    (state),
    .opcode (opcode),
    .nxt    (state_nxt)
  );

  cpu_seq_decode u_dec (
    .rst  (rst),
    .st   (state),
    .ctrl (ctrl)
  );

  always_ff @(posedge clk) begin
    if (rst) state <= ST_FETCH0;
    else     state <= state_nxt;
  end

  assign ir_wr     = ctrl.ir_wr;
  assign pc_wr     = ctrl.pc_wr;
  assign br_en     = ctrl.br_en;
  assign pc_sel    = ctrl.pc_sel;
  assign addr_sel  = ctrl.addr_sel;
  assign mem_rd    = ctrl.mem_rd;
  assign mem_wr    = ctrl.mem_wr;
  assign alu_a_sel = ctrl.alu_a_sel;
  assign alu_b_sel = ctrl.alu_b_sel;
  assign alu_class = ctrl.alu_class;
  assign dst_sel   = ctrl.dst_sel;
  assign reg_wr    = ctrl.reg_wr;
  assign wb_sel    = ctrl.wb_sel;

  // R1: reset silences every enable in the same cycle
  always_comb begin
    if (rst) begin
      p_reset_quiet_r1: assert (ir_wr == '0 && !pc_wr && !reg_wr && !mem_wr && !mem_rd && !br_en)
        else $error("p_reset_quiet_r1");
    end
  end

  p_fetch_step_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH0 || state == ST_FETCH1 || state == ST_FETCH2)
      |=> (4'(state) == 4'($past(state)) + 4'd1))
    else $error("p_fetch_step_r2");

  p_fetch_to_decode_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH3) |=> (state == ST_DECODE))
    else $error("p_fetch_to_decode_r3");

  p_load_chain_r5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_MEM_READ) |=> (state == ST_MEM_WB))
    else $error("p_load_chain_r5");

  p_undef_return_r11: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DECODE && opcode != OP_LB && opcode != OP_SB && opcode != OP_RTYPE &&
     opcode != OP_BEQ && opcode != OP_JUMP && opcode != OP_ADDI) |=> (state == ST_FETCH0))
    else $error("p_undef_return_r11");

  p_mem_excl_r12: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr))
    else $error("p_mem_excl_r12");

  p_ir_onehot_r12: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ir_wr))
    else $error("p_ir_onehot_r12");

endmodule

// File: tb/cpu_seq_ctrl_test.sv
`timescale 1ns/1ps
module cpu_seq_ctrl_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'd0;
  logic [3:0] ir_wr;
  logic       pc_wr, br_en, addr_sel, mem_rd, mem_wr, alu_a_sel, dst_sel, reg_wr, wb_sel;
  logic [1:0] pc_sel, alu_b_sel, alu_class;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  cpu_seq_ctrl uut (
    .clk(clk), .rst(rst), .opcode(opcode), .ir_wr(ir_wr), .pc_wr(pc_wr), .br_en(br_en),
    .pc_sel(pc_sel), .addr_sel(addr_sel), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .alu_class(alu_class),
    .dst_sel(dst_sel), .reg_wr(reg_wr), .wb_sel(wb_sel)
  );

  // {ir_wr, pc_wr, br_en, pc_sel, addr_sel, mem_rd, mem_wr, alu_a_sel, alu_b_sel, alu_class, dst_sel, reg_wr, wb_sel}
  logic [18:0] obs;
  assign obs = {ir_wr, pc_wr, br_en, pc_sel, addr_sel, mem_rd, mem_wr, alu_a_sel,
                alu_b_sel, alu_class, dst_sel, reg_wr, wb_sel};

  // Bench step numbers: 0-3 fetch, 4 decode, 5 address, 6 read, 7 load write,
  // 8 store, 9 reg exec, 10 reg write, 11 branch, 12 jump, 13 imm exec, 14 imm write.
  function automatic logic [18:0] expect_out(input int s);
    logic [3:0] irw; logic pw, be, as, mr, mw, aa, ds, rw, ws;
    logic [1:0] ps, bs, ac;
    irw = 0; pw = 0; be = 0; as = 0; mr = 0; mw = 0; aa = 0; ds = 0; rw = 0; ws = 0;
    ps = 0; bs = 0; ac = 0;
    if (s < 4) begin irw = 4'(1 << s); mr = 1; pw = 1; bs = 2'b01; end
    else case (s)
      4:  bs = 2'b11;
      5, 13: begin aa = 1; bs = 2'b10; end
      6:  begin mr = 1; as = 1; end
      7:  begin rw = 1; ws = 1; end
      8:  begin mw = 1; as = 1; end
      9:  begin aa = 1; ac = 2'b10; end
      10: begin rw = 1; ds = 1; end
      11: begin aa = 1; ac = 2'b01; be = 1; ps = 2'b01; end
      12: begin pw = 1; ps = 2'b10; end
      14: rw = 1;
      default: ;
    endcase
    return {irw, pw, be, ps, as, mr, mw, aa, bs, ac, ds, rw, ws};
  endfunction

  function automatic string tag_of(input int s);
    case (s)
      0, 1, 2, 3: return "R2";
      4:  return "R3";
      5:  return "R4";
      6, 7: return "R5";
      8:  return "R6";
      9, 10: return "R7";
      11: return "R9";
      12: return "R10";
      default: return "R8";
    endcase
  endfunction

  function automatic int model_next(input int s, input logic [5:0] op);
    if (s < 4) return s + 1;
    case (s)
      4: case (op)
           6'b100000, 6'b101000: return 5;
           6'b000000: return 9;
           6'b000100: return 11;
           6'b000010: return 12;
           6'b001000: return 13;
           default:   return 0;
         endcase
      5:  return (op == 6'b101000) ? 8 : 6;
      6:  return 7;
      9:  return 10;
      13: return 14;
      default: return 0;
    endcase
  endfunction

  function automatic int expect_len(input logic [5:0] op);
    case (op)
      6'b100000: return 4 + 4;
      6'b101000, 6'b000000, 6'b001000: return 4 + 3;
      6'b000100, 6'b000010: return 4 + 2;
      default: return 4 + 1;
    endcase
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  initial begin
    int st;
    int cyc;
    repeat (2) @(negedge clk);
    chk(32'(obs), 32'd0, "R1", "outputs under reset");
    rst = 1'b0;
    #0.1;
    chk(32'(obs), 32'(expect_out(0)), "R1", "fetch byte 0 after release");

    // Sweep every opcode from fetch byte 0 back to fetch byte 0.
    for (int op = 0; op < 64; op++) begin
      opcode = 6'(op);
      st = 0;
      cyc = 0;
      do begin
        chk(32'(obs), 32'(expect_out(st)), tag_of(st), $sformatf("op %02h step %0d", op, st));
        st = model_next(st, 6'(op));
        @(negedge clk);
        cyc++;
      end while (st != 0 && cyc < 20);
      chk(32'(cyc), 32'(expect_len(6'(op))),
          (expect_len(6'(op)) == 5) ? "R11" : "R5-R10 length", $sformatf("op %02h cycles", op));
    end

    // R4: opcode seen in the address cycle picks the path.
    opcode = 6'b100000;
    repeat (5) @(negedge clk);
    chk(32'(obs), 32'(expect_out(5)), "R4", "address cycle");
    opcode = 6'b101000;
    @(negedge clk);
    chk(32'(obs), 32'(expect_out(8)), "R4", "late store opcode takes store path");
    @(negedge clk);
    chk(32'(obs), 32'(expect_out(0)), "R6", "back to fetch after store");

    // R1: reset during decode.
    opcode = 6'b000000;
    repeat (4) @(negedge clk);
    chk(32'(obs), 32'(expect_out(4)), "R3", "decode before reset");
    rst = 1'b1;
    #0.1;
    chk(32'(obs), 32'd0, "R1", "outputs zero with reset mid-instruction");
    @(negedge clk);
    chk(32'(obs), 32'd0, "R1", "outputs zero one edge into reset");
    rst = 1'b0;
    #0.1;
    chk(32'(obs), 32'(expect_out(0)), "R1", "restart at fetch byte 0");
    @(negedge clk);
    chk(32'(obs), 32'(expect_out(1)), "R2", "fetch byte 1 after restart");

    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule